// File: doc/BRIEF.md
# Remote Miss Bias Controller

This block watches the last-level cache misses of one socket in a multi-socket system. It sorts each miss by where the line was served from: the local memory node or a remote one. Misses are counted over an epoch, and the epoch is marked by a single-cycle pulse.

At each pulse the block works out which share of the epoch's misses were remote. It compares that share against two programmable thresholds and updates a single enable. The replacement logic uses this enable to favour keeping remote-homed lines.

The enable switches with hysteresis:
- It turns on once the remote share rises above the upper threshold.
- It turns off once the share drops below the lower threshold.
- Anywhere between the two thresholds it keeps its previous value.

Each threshold is an 8-bit fraction of 256. Software would normally program 128 for one half and 26 for roughly one tenth. The comparison cross-multiplies, `remote * 256` against `threshold * total`, so no divider is needed.

Top module: `remote_bias_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `biasEn` is 0 and both miss counters are zero.
- R2: A cycle with `missValid` high adds one to the remote counter when `missRemote` is 1, and to the local counter when it is 0. A miss that arrives in the same cycle as `epochPulse` is counted in the new epoch, not the one being evaluated.
- R3: Each counter saturates at 2^CNT_W-1 and never wraps. Evaluation uses the saturated values.
- R4: At an epoch pulse with `biasEn` = 0, `biasEn` becomes 1 when remote*256 > highWm*(local+remote).
- R5: At an epoch pulse with `biasEn` = 1, `biasEn` becomes 0 when remote*256 < lowWm*(local+remote).
- R6: At an epoch pulse where the condition for the current state is not met, including exact equality with a threshold, `biasEn` keeps its value.
- R7: At an epoch pulse where local+remote = 0, `biasEn` keeps its value.
- R8: `biasEn` is registered. It changes only at the clock edge where `epochPulse` is sampled high, and both counters clear at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | One miss this cycle |
| missRemote | input | 1 | 1 = miss served by a remote node, 0 = local |
| epochPulse | input | 1 | Ends the epoch: evaluate, then clear the counters |
| highWm | input | 8 | Upper threshold, in units of 1/256 |
| lowWm | input | 8 | Lower threshold, in units of 1/256 |
| biasEn | output | 1 | Remote-line retention bias enable |

## Verification
The bench builds the block with `CNT_W` = 4, so a counter saturates at 15. That makes saturation reachable within a short epoch, and the stimulus is chosen so that a wrapping counter would reach the opposite decision to a saturating one. The thresholds keep their 8-bit width. Directed epochs land exactly on a threshold and test a miss that coincides with the pulse. Randomized epochs with randomly reprogrammed thresholds then cover a mix of on, off and hold decisions.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  // Strobes issued by the control to the counting datapath
  typedef struct packed {
    logic incLocal;
    logic incRemote;
    logic epochClr;
  } dpStrobe_t;
endpackage

// File: rtl/rmb_datapath.sv
module rmb_datapath
  import rmb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WM_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [WM_W-1:0]  highWm,
  input  logic [WM_W-1:0]  lowWm,
  output logic [CNT_W-1:0] localCnt,
  output logic [CNT_W-1:0] remoteCnt,
  output logic             aboveHigh,
  output logic             belowLow,
  output logic             anyMiss
);
  localparam int PROD_W = CNT_W + 1 + WM_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [2];
  logic             inc [2];

  assign inc[0] = strb.incLocal;
  assign inc[1] = strb.incRemote;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt[g] <= '0;
      else if (strb.epochClr)
        cnt[g] <= {{(CNT_W-1){1'b0}}, inc[g]};
      else if (inc[g] && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign localCnt  = cnt[0];
  assign remoteCnt = cnt[1];

  logic [CNT_W:0]    total;
  logic [PROD_W-1:0] remScaled, hiProd, loProd;

  always_comb begin
    total     = {1'b0, cnt[0]} + {1'b0, cnt[1]};
    remScaled = {1'b0, cnt[1], {WM_W{1'b0}}};
    hiProd    = PROD_W'(highWm) * PROD_W'(total);
    loProd    = PROD_W'(lowWm) * PROD_W'(total);
    aboveHigh = remScaled > hiProd;
    belowLow  = remScaled < loProd;
    anyMiss   = total != '0;
  end
endmodule

// File: rtl/rmb_control.sv
module rmb_control
  import rmb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      missValid,
  input  logic      missRemote,
  input  logic      epochPulse,
  input  logic      aboveHigh,
  input  logic      belowLow,
  input  logic      anyMiss,
  output dpStrobe_t strb,
  output logic      biasEn
);
  logic biasNext;

  always_comb begin
    strb.incLocal  = missValid && !missRemote;
    strb.incRemote = missValid && missRemote;
    strb.epochClr  = epochPulse;
    biasNext       = biasEn;
    if (epochPulse && anyMiss) begin
      if (!biasEn && aboveHigh)
        biasNext = 1'b1;
      else if (biasEn && belowLow)
        biasNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) biasEn <= 1'b0;
    else       biasEn <= biasNext;
  end
endmodule

// File: rtl/remote_bias_ctrl.sv
module remote_bias_ctrl
  import rmb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WM_W  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            missValid,
  input  logic            missRemote,
  input  logic            epochPulse,
  input  logic [WM_W-1:0] highWm,
  input  logic [WM_W-1:0] lowWm,
  output logic            biasEn
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] localCnt, remoteCnt;
  logic             aboveHigh, belowLow, anyMiss;

  rmb_datapath #(.CNT_W(CNT_W), .WM_W(WM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .highWm(highWm), .lowWm(lowWm),
    .localCnt(localCnt), .remoteCnt(remoteCnt),
    .aboveHigh(aboveHigh), .belowLow(belowLow), .anyMiss(anyMiss)
  );

  rmb_control u_ctl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missRemote(missRemote),
    .epochPulse(epochPulse), .aboveHigh(aboveHigh), .belowLow(belowLow),
    .anyMiss(anyMiss), .strb(strb), .biasEn(biasEn)
  );
endmodule

// File: rtl/remote_bias_ctrl_chk.sv
module remote_bias_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int WM_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             missValid,
  input logic             missRemote,
  input logic             epochPulse,
  input logic [WM_W-1:0]  highWm,
  input logic [WM_W-1:0]  lowWm,
  input logic             biasEn,
  input logic [CNT_W-1:0] localCnt,
  input logic [CNT_W-1:0] remoteCnt
);
  localparam int PROD_W = CNT_W + 1 + WM_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PROD_W-1:0] chkTotal, chkRem;
  assign chkTotal = PROD_W'(localCnt) + PROD_W'(remoteCnt);
  assign chkRem   = PROD_W'(remoteCnt) << WM_W;

  p_reset_off_r1: assert property (@(posedge clk)
    $rose(rstN) |-> !biasEn && localCnt == '0 && remoteCnt == '0);

  p_count_local_r2: assert property (@(posedge clk) disable iff (!rstN)
    missValid && !missRemote && !epochPulse && localCnt != CNT_MAX
    |=> localCnt == $past(localCnt) + 1'b1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    remoteCnt == CNT_MAX && !epochPulse |=> remoteCnt == CNT_MAX);

  p_turn_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    epochPulse && !biasEn && chkRem > PROD_W'(highWm) * chkTotal |=> biasEn);

  p_turn_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    epochPulse && biasEn && chkRem < PROD_W'(lowWm) * chkTotal |=> !biasEn);

  p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    epochPulse && chkTotal == '0 |=> $stable(biasEn));

  p_epoch_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !epochPulse |=> $stable(biasEn));
endmodule

bind remote_bias_ctrl remote_bias_ctrl_chk #(.CNT_W(CNT_W), .WM_W(WM_W)) u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missRemote(missRemote),
  .epochPulse(epochPulse), .highWm(highWm), .lowWm(lowWm), .biasEn(biasEn),
  .localCnt(localCnt), .remoteCnt(remoteCnt)
);

// File: tb/remote_bias_ctrl_tb.sv
`timescale 1ns/1ps
module remote_bias_ctrl_tb;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0, missRemote = 1'b0, epochPulse = 1'b0;
  logic [7:0] highWm = 8'd128, lowWm = 8'd26;
  logic biasEn;

  int checks = 0, failures = 0;
  int mLoc = 0, mRem = 0, mBias = 0;
  string mTag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  remote_bias_ctrl #(.CNT_W(CNT_W), .WM_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missRemote(missRemote),
    .epochPulse(epochPulse), .highWm(highWm), .lowWm(lowWm), .biasEn(biasEn)
  );

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mLoc = 0; mRem = 0; mBias = 0; mTag = "R1";
    end else if (epochPulse) begin
      int tot;
      tot = mLoc + mRem;
      if (tot == 0) mTag = "R7";
      else if (mBias == 0 && mRem * 256 > int'(highWm) * tot) begin mBias = 1; mTag = "R4"; end
      else if (mBias == 1 && mRem * 256 < int'(lowWm) * tot) begin mBias = 0; mTag = "R5"; end
      else mTag = "R6";
      mLoc = (missValid && !missRemote) ? 1 : 0;
      mRem = (missValid && missRemote) ? 1 : 0;
    end else begin
      mTag = "R8";
      if (missValid && !missRemote && mLoc < CMAX) mLoc++;
      if (missValid && missRemote && mRem < CMAX) mRem++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s biasEn actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) check(rstN ? mTag : "R1", int'(biasEn), mBias);
  end

  task automatic step(input logic v, input logic r, input logic e);
    @(negedge clk);
    missValid = v; missRemote = r; epochPulse = e;
  endtask

  task automatic misses(input int nLoc, input int nRem);
    for (int i = 0; i < nLoc; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < nRem; i++) step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic epoch(input string tag, input int expBias);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(tag, int'(biasEn), expBias);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(biasEn), 0);
    rstN = 1'b1;
    epoch("R7", 0);                           // empty epoch
    misses(2, 6); epoch("R4", 1);             // 1536 > 1024
    epoch("R7", 1);                           // empty epoch while on
    misses(9, 1); epoch("R5", 0);             // 256 < 260
    misses(4, 4); epoch("R6", 0);             // exactly at high: hold
    misses(2, 6); epoch("R4", 1);
    lowWm = 8'd64;
    misses(3, 1); epoch("R6", 1);             // 256 == 64*4: hold
    misses(9, 1); epoch("R5", 0);
    lowWm = 8'd26;
    // a miss coinciding with the pulse belongs to the new epoch
    misses(2, 0);
    step(1'b1, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b0);
    epoch("R2", 1);                           // rem=1 loc=0 -> on
    // saturation of the local counter: 20 local, 2 remote, low 64
    lowWm = 8'd64;
    misses(20, 2); epoch("R3", 0);
    // saturation of the remote counter: 5 local, 17 remote, high 128
    misses(5, 17); epoch("R3", 1);
    // randomized traffic and thresholds
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 40) == 0) begin
        highWm = 8'($urandom_range(0, 255));
        lowWm  = 8'($urandom_range(0, 255));
      end
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 9) == 0);
    end
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule